// File: doc/BRIEF.md
# Codec Link Warm Reset Controller

This block lets a host wake a serial audio codec by a warm reset. A one-bit host write asks for the reset. The codec's bit clock is brought into the master clock domain and watched. As long as edges keep arriving, a read-only status flag shows the link as active. A warm reset is only needed, and only allowed, when that link clock has stopped.

When a request is accepted, a control flag is raised and the SYNC line towards the codec is held high. A down-counter measures a fixed pulse, 32 master-clock cycles by default (about 1.3 µs at 24.576 MHz). The control flag then clears itself. When the flag is low, the SYNC line carries whatever the normal frame logic drives.

A read port returns both flags at fixed bit positions, so host software can poll them.

Top module: `codec_link_wrst`

## Requirements
- R1: After reset, every bit of `rd_data` is 0 and `sync_out` equals `frame_sync_in`.
- R2: A write (`wr_en`=1, `wr_data`=1) while the link flag is 0 and no pulse is running sets the warm-reset flag (`rd_data` bit 2) on the next clock edge.
- R3: A write of 1 while the link flag (`rd_data` bit 3) reads 1 has no effect: bit 2 stays 0 and `sync_out` keeps following `frame_sync_in`.
- R4: Once set, the warm-reset flag stays 1 for exactly PULSE_CYCLES (default 32) master-clock cycles and then returns to 0 by itself.
- R5: A write of 1 during a running pulse is ignored, so the total pulse length is still PULSE_CYCLES.
- R6: `sync_out` is 1 while the warm-reset flag is 1. Otherwise it equals `frame_sync_in`.
- R7: The link flag rises within 4 master-clock cycles after the synchronized bit clock shows an edge.
- R8: The link flag falls to 0 once no bit clock edge has been seen for IDLE_WINDOW (default 64) master-clock cycles. It falls no later than IDLE_WINDOW+5 cycles after the last input edge.
- R9: `rd_data` returns the warm-reset flag at bit 2 and the link flag at bit 3. All other bits read 0.
- R10: A write with `wr_data`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle host write strobe |
| wr_data | input | 1 | Write data for the warm-reset flag |
| bit_clk | input | 1 | Codec bit clock (asynchronous) |
| frame_sync_in | input | 1 | SYNC value from the normal frame logic |
| sync_out | output | 1 | SYNC line to the codec |
| rd_data | output | RD_W (8) | Register read-back value |

## Verification
The assertions take two things for granted. First, `wr_en` is a one-cycle strobe sampled on the master clock. Second, a running bit clock has gaps much shorter than the idle window, so that once the link is active it stays active while edges keep coming. The stimulus toggles `bit_clk` every 3.5 master cycles, a rate no multiple of the master period, so that the synchronizer sees edges in varying phases. When the link has to look idle, the bench stops `bit_clk` for well over the window. Host writes are driven on the falling clock edge and last exactly one cycle.

// File: rtl/wrst_pkg.sv
`timescale 1ns/1ps
package wrst_pkg;
    // Read-back field positions decoded by host software
    localparam int unsigned WRST_POS = 2;
    localparam int unsigned LINK_POS = 3;
    localparam int unsigned RD_W_DEF = 8;
endpackage

// File: rtl/wrst_link_activity.sv
`timescale 1ns/1ps
module wrst_link_activity #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IDLE_WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk_i,
    output logic active_o
);
    localparam int unsigned CW = (IDLE_WINDOW > 2) ? $clog2(IDLE_WINDOW) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(IDLE_WINDOW - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [CW-1:0]          cnt;
        logic                   active;
    } det_t;

    det_t st_q, st_d;
    logic edge_seen;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], bit_clk_i};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        edge_seen = st_q.sync[SYNC_STAGES-1] ^ st_q.prev;
        if (edge_seen) begin
            st_d.cnt    = RELOAD;
            st_d.active = 1'b1;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;

    // R7: a synchronized edge marks the link active on the next cycle
    p_edge_sets_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> st_q.active);
    // R8: an exhausted window with no fresh edge drops the link flag
    p_idle_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !edge_seen) |=> !st_q.active);
    // R8: window counter only ever counts down between edges
    p_window_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_seen && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
endmodule

// File: rtl/wrst_pulse_timer.sv
`timescale 1ns/1ps
module wrst_pulse_timer #(
    parameter int unsigned PULSE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic link_active_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;
    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = req_i && !link_active_i && !st_q.busy;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = LOAD;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    // R2: a pulse can only begin out of an idle link
    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(!link_active_i));
    // R3: request during active link leaves the flag low
    p_active_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && link_active_i && !st_q.busy) |=> !st_q.busy);
    // R4: the flag drops only after the count has run out
    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(st_q.cnt) == '0);
    // R5: a running pulse keeps counting down, even under new requests
    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/codec_link_wrst.sv
`timescale 1ns/1ps
module codec_link_wrst #(
    parameter int unsigned PULSE_CYCLES = 32,
    parameter int unsigned IDLE_WINDOW  = 64,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned RD_W         = wrst_pkg::RD_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_data,
    input  logic            bit_clk,
    input  logic            frame_sync_in,
    output logic            sync_out,
    output logic [RD_W-1:0] rd_data
);
    import wrst_pkg::*;

    logic link_active;
    logic wrst_flag;

    wrst_link_activity #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_WINDOW (IDLE_WINDOW)
    ) u_activity (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_clk_i (bit_clk),
        .active_o  (link_active)
    );

    wrst_pulse_timer #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (wr_en && wr_data),
        .link_active_i (link_active),
        .busy_o        (wrst_flag)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[WRST_POS] = wrst_flag;
        rd_data[LINK_POS] = link_active;
    end

    assign sync_out = wrst_flag ? 1'b1 : frame_sync_in;

    // R6: SYNC is forced high for the whole pulse
    p_sync_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WRST_POS] |-> sync_out);
    // R9: no stray bits in the read-back word
    p_read_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_data) <= 2);
    // R10: a zero write never starts a pulse
    p_zero_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data && !rd_data[WRST_POS]) |=> !rd_data[WRST_POS]);
endmodule

// File: tb/tb_codec_link_wrst.sv
`timescale 1ns/1ps
module tb_codec_link_wrst;
    localparam int PULSE = 32;
    localparam int RW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_data = 1'b0;
    logic          bit_clk = 1'b0;
    logic          frame_sync_in = 1'b0;
    logic          bclk_run = 1'b0;
    logic          sync_out;
    logic [RW-1:0] rd_data;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    codec_link_wrst dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bit_clk(bit_clk), .frame_sync_in(frame_sync_in),
        .sync_out(sync_out), .rd_data(rd_data)
    );

    always #5 clk = ~clk;
    always begin
        #35;
        if (bclk_run) bit_clk = ~bit_clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic host_write(input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 rd_data in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data after reset", int'(rd_data), 0);
        frame_sync_in = 1'b1; #1;
        chk("R1 sync follows frame high", int'(sync_out), 1);
        frame_sync_in = 1'b0; #1;
        chk("R1 sync follows frame low", int'(sync_out), 0);
    endtask

    task automatic t_write_zero();
        host_write(1'b0);
        chk("R10 zero write ignored", int'(rd_data), 0);
        wait_cyc(3);
        chk("R10 still idle", int'(rd_data), 0);
    endtask

    task automatic t_pulse(input bit rewrite);
        int cnt = 0;
        int sync_bad = 0;
        host_write(1'b1);
        chk("R2 flag set bit 2", int'(rd_data[2]), 1);
        chk("R9 read map during pulse", int'(rd_data), 4);
        while (rd_data[2] && cnt < 200) begin
            if (sync_out !== 1'b1) sync_bad++;
            if (rewrite && cnt == 10) begin wr_en = 1'b1; wr_data = 1'b1; end
            else begin wr_en = 1'b0; wr_data = 1'b0; end
            cnt++;
            @(negedge clk);
        end
        wr_en = 1'b0; wr_data = 1'b0;
        chk("R6 sync forced during pulse", sync_bad, 0);
        if (rewrite) chk("R5 no restart on rewrite", cnt, PULSE);
        else         chk("R4 pulse length", cnt, PULSE);
        frame_sync_in = 1'b1; #1;
        chk("R6 sync released to frame", int'(sync_out), 1);
        frame_sync_in = 1'b0; #1;
        chk("R6 sync released low", int'(sync_out), 0);
    endtask

    task automatic t_active_gate();
        bclk_run = 1'b1;
        wait_cyc(12);
        chk("R7 link active", int'(rd_data[3]), 1);
        chk("R9 read map active", int'(rd_data), 8);
        frame_sync_in = 1'b1;
        host_write(1'b1);
        chk("R3 write ignored while active", int'(rd_data[2]), 0);
        chk("R3 sync follows frame", int'(sync_out), 1);
        wait_cyc(2);
        chk("R3 flag stays 0", int'(rd_data[2]), 0);
        frame_sync_in = 1'b0;
    endtask

    task automatic t_idle();
        bclk_run = 1'b0;
        wait_cyc(59);
        chk("R8 still active inside window", int'(rd_data[3]), 1);
        wait_cyc(14);
        chk("R8 idle after window", int'(rd_data[3]), 0);
        chk("R9 read map idle", int'(rd_data), 0);
    endtask

    initial begin
        t_reset();
        t_write_zero();
        t_pulse(1'b0);
        t_pulse(1'b1);
        t_active_gate();
        t_idle();
        t_pulse(1'b0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule